// File: doc/BRIEF.md
# Stage-2 Translation Cache with Address-Space-Tagged Invalidation

This block is a small, fully associative cache of stage-2 (guest-physical to physical) translations. Each slot remembers a VMID, a guest-physical page number (4 KB units), a lookup level, a granule code, a flag that marks a non-leaf (partial) walk entry, and a tag that says whether the page belongs to the secure or the non-secure guest-physical space. A walker fills slots through a fill port. Translators probe the cache through a combinational lookup port keyed by VMID, page and address space.

Maintenance software issues invalidate-by-guest-physical-address commands. The command port takes the raw 64-bit operand, the security state of the requester, a last-level flag and a range flag. The block decodes which address space is targeted and which pages are covered, then sweeps the slots one per clock. It clears every slot that matches and pulses a done strobe once the sweep ends. Fills are held off while a sweep runs.

Top module: `s2_tlb_ipaspace`

## Requirements
- R1: A requester in the non-secure state (inv_req_secure=0) always targets the non-secure space, whatever operand bit 63 holds.
- R2: A secure requester (inv_req_secure=1) targets the non-secure space when operand bit 63 is 1 and the secure space when bit 63 is 0.
- R3: In single-page mode the page number is operand bits [39:0] when parameter PA52=1, and bits [35:0] otherwise. Higher operand bits below 63 are ignored.
- R4: A slot is cleared only when it is valid and its VMID equals inv_vmid, its page matches, and its space tag equals the decoded space.
- R5: With inv_last=1, partial slots survive a matching invalidate. With inv_last=0 they are cleared like leaf slots.
- R6: In range mode the operand fields are base [36:0], level hint [38:37], count [43:39], scale [45:44] and granule [47:46]. The covered pages are base up to but not including base + ((count+1) << (5*scale+1)). A slot must also carry the same granule code, and its level must equal the hint unless the hint is 0, which accepts any level.
- R7: A filled slot is tagged secure only when fill_secure=1 and is tagged non-secure otherwise.
- R8: When lu_s1_bypass=1 the lookup uses the secure space if lu_req_secure=1 and the non-secure space if it is 0. When lu_s1_bypass=0 it uses the space given by lu_s1_secure.
- R9: An accepted command holds inv_busy high for exactly ENTRIES cycles. inv_done is then high for one cycle as inv_busy falls. Commands presented while busy are ignored.
- R10: fill_ready is low throughout a sweep, and a fill presented then is dropped.
- R11: A fill goes to the lowest-numbered invalid slot. When no slot is invalid it replaces slots in round-robin order starting at slot 0.
- R12: lu_hit requires a valid slot with equal VMID, equal page and equal space tag. It then returns that slot's level and partial flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill accepted this cycle (low during a sweep) |
| fill_vmid | input | VMID_W | VMID of the new translation |
| fill_page | input | PAGE_W | Guest-physical page number |
| fill_level | input | 2 | Lookup level of the entry |
| fill_gran | input | 2 | Granule code of the entry |
| fill_partial | input | 1 | Entry is a non-leaf walk entry |
| fill_secure | input | 1 | Entry belongs to the secure guest-physical space |
| lu_vmid | input | VMID_W | Lookup VMID |
| lu_page | input | PAGE_W | Lookup page number |
| lu_req_secure | input | 1 | Requester is in the secure state |
| lu_s1_bypass | input | 1 | Stage 1 is disabled for this access |
| lu_s1_secure | input | 1 | Stage 1 produced a secure output address |
| lu_hit | output | 1 | Lookup found a matching slot |
| lu_level | output | 2 | Level of the hit slot |
| lu_partial | output | 1 | Partial flag of the hit slot |
| inv_valid | input | 1 | Invalidate command request |
| inv_operand | input | 64 | Raw operand of the command |
| inv_vmid | input | VMID_W | VMID to invalidate |
| inv_req_secure | input | 1 | Requester of the command is secure |
| inv_last | input | 1 | Touch leaf entries only |
| inv_range | input | 1 | Operand carries a range rather than one page |
| inv_busy | output | 1 | Sweep in progress |
| inv_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench places a secure and a non-secure copy of the same page side by side. Every combination of requester state and operand bit 63 must remove exactly one of them. A design that ignored the space tag would wipe both, and one that read bit 63 for non-secure requesters would miss. Operand bit 40 is set to prove it is ignored, and bit 39 is set to prove it is used. Range commands probe the last page inside the range, the first page past it, a granule mismatch and a level-hint mismatch, so an off-by-one end or a missing granule check leaves the wrong slot alive. The sweep is timed cycle by cycle while a second command and a fill are presented mid-sweep. After every slot is full, the bench checks replacement order and that a freed slot is reused ahead of the round-robin pointer.

// File: rtl/s2_tlb_ipaspace.sv
module s2_tlb_ipaspace #(
  parameter int ENTRIES = 8,
  parameter int VMID_W  = 8,
  parameter int PAGE_W  = 40,
  parameter bit PA52    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic [PAGE_W-1:0] fill_page,
  input  logic [1:0]        fill_level,
  input  logic [1:0]        fill_gran,
  input  logic              fill_partial,
  input  logic              fill_secure,
  input  logic [VMID_W-1:0] lu_vmid,
  input  logic [PAGE_W-1:0] lu_page,
  input  logic              lu_req_secure,
  input  logic              lu_s1_bypass,
  input  logic              lu_s1_secure,
  output logic              lu_hit,
  output logic [1:0]        lu_level,
  output logic              lu_partial,
  input  logic              inv_valid,
  input  logic [63:0]       inv_operand,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic              inv_req_secure,
  input  logic              inv_last,
  input  logic              inv_range,
  output logic              inv_busy,
  output logic              inv_done
);
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LEN_W    = PAGE_W + 1;
  localparam int ADDR_TOP = PA52 ? 39 : 35;

  logic [ENTRIES-1:0] e_v;
  logic [VMID_W-1:0]  e_vmid [ENTRIES];
  logic [PAGE_W-1:0]  e_page [ENTRIES];
  logic [1:0]         e_lvl  [ENTRIES];
  logic [1:0]         e_gran [ENTRIES];
  logic [ENTRIES-1:0] e_part;
  logic [ENTRIES-1:0] e_sec;

  logic [IDX_W-1:0]  sw_idx, rr;
  logic [VMID_W-1:0] c_vmid;
  logic [PAGE_W-1:0] c_page;
  logic [LEN_W-1:0]  c_end;
  logic              c_sec, c_last, c_range;
  logic [1:0]        c_ttl, c_tg;

  // lookup
  logic lu_sec;
  assign lu_sec = lu_s1_bypass ? lu_req_secure : lu_s1_secure;

  always_comb begin
    lu_hit = 1'b0;
    lu_level = '0;
    lu_partial = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (e_v[i] && e_vmid[i] == lu_vmid && e_page[i] == lu_page && e_sec[i] == lu_sec) begin
        lu_hit = 1'b1;
        lu_level = e_lvl[i];
        lu_partial = e_part[i];
      end
    end
  end

  // victim choice
  logic             free_found;
  logic [IDX_W-1:0] free_idx, victim;
  always_comb begin
    free_found = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!e_v[i]) begin
        free_found = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
  assign victim = free_found ? free_idx : rr;
  assign fill_ready = !inv_busy;

  logic do_fill;
  assign do_fill = fill_valid && fill_ready;

  // command decode
  logic              accept;
  logic              d_sec;
  logic [PAGE_W-1:0] d_page;
  logic [5:0]        d_cnt;
  logic [4:0]        d_sh;
  logic [LEN_W-1:0]  d_end;
  assign accept = inv_valid && !inv_busy;
  assign d_sec  = inv_req_secure && !inv_operand[63];
  assign d_page = inv_range ? PAGE_W'(inv_operand[36:0]) : PAGE_W'(inv_operand[ADDR_TOP:0]);
  assign d_cnt  = {1'b0, inv_operand[43:39]} + 6'd1;
  assign d_sh   = 5'(inv_operand[45:44]) * 5'd5 + 5'd1;
  assign d_end  = {1'b0, d_page} + (LEN_W'(d_cnt) << d_sh);

  // sweep match for the current slot
  logic addr_ok, rng_ok, kill, sw_last;
  assign addr_ok = c_range ? ({1'b0, e_page[sw_idx]} >= {1'b0, c_page} &&
                              {1'b0, e_page[sw_idx]} < c_end)
                           : (e_page[sw_idx] == c_page);
  assign rng_ok  = !c_range || (e_gran[sw_idx] == c_tg &&
                                (c_ttl == 2'd0 || c_ttl == e_lvl[sw_idx]));
  assign kill    = inv_busy && e_v[sw_idx] && e_vmid[sw_idx] == c_vmid && addr_ok &&
                   e_sec[sw_idx] == c_sec && !(c_last && e_part[sw_idx]) && rng_ok;
  assign sw_last = sw_idx == IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v <= '0;
      inv_busy <= 1'b0;
      inv_done <= 1'b0;
      sw_idx <= '0;
      rr <= '0;
      c_vmid <= '0;
      c_page <= '0;
      c_end <= '0;
      c_sec <= 1'b0;
      c_last <= 1'b0;
      c_range <= 1'b0;
      c_ttl <= '0;
      c_tg <= '0;
    end else begin
      inv_done <= 1'b0;
      if (do_fill) begin
        e_v[victim] <= 1'b1;
        if (!free_found) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
      if (accept) begin
        inv_busy <= 1'b1;
        sw_idx <= '0;
        c_vmid <= inv_vmid;
        c_page <= d_page;
        c_end <= d_end;
        c_sec <= d_sec;
        c_last <= inv_last;
        c_range <= inv_range;
        c_ttl <= inv_operand[38:37];
        c_tg <= inv_operand[47:46];
      end else if (inv_busy) begin
        if (kill) e_v[sw_idx] <= 1'b0;
        if (sw_last) begin
          inv_busy <= 1'b0;
          inv_done <= 1'b1;
        end else begin
          sw_idx <= sw_idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      e_vmid[victim] <= fill_vmid;
      e_page[victim] <= fill_page;
      e_lvl[victim]  <= fill_level;
      e_gran[victim] <= fill_gran;
      e_part[victim] <= fill_partial;
      e_sec[victim]  <= fill_secure;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |=> !inv_done);
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> (!inv_busy && $past(inv_busy)));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_busy) |=> inv_busy);
  p_fill_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> !fill_ready);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_busy && !inv_done && $past(inv_busy)) |-> $stable(c_sec));
endmodule

// File: tb/s2_tlb_ipaspace_tb.sv
module s2_tlb_ipaspace_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        fill_valid = 0, fill_ready;
  logic [7:0]  fill_vmid = 0;
  logic [39:0] fill_page = 0;
  logic [1:0]  fill_level = 0, fill_gran = 0;
  logic        fill_partial = 0, fill_secure = 0;
  logic [7:0]  lu_vmid = 0;
  logic [39:0] lu_page = 0;
  logic        lu_req_secure = 0, lu_s1_bypass = 0, lu_s1_secure = 0;
  logic        lu_hit, lu_partial;
  logic [1:0]  lu_level;
  logic        inv_valid = 0;
  logic [63:0] inv_operand = 0;
  logic [7:0]  inv_vmid = 0;
  logic        inv_req_secure = 0, inv_last = 0, inv_range = 0;
  logic        inv_busy, inv_done;

  s2_tlb_ipaspace u_dut (.*);

  int checks = 0, failures = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic fill(input logic [7:0] vm, input logic [39:0] pg, input logic [1:0] lv,
                      input logic [1:0] gr, input logic part, input logic sec);
    @(negedge clk);
    fill_valid = 1; fill_vmid = vm; fill_page = pg; fill_level = lv;
    fill_gran = gr; fill_partial = part; fill_secure = sec;
    @(negedge clk);
    fill_valid = 0;
  endtask

  // returns hit via output; lookup is combinational
  task automatic look(input logic [7:0] vm, input logic [39:0] pg, input logic rs,
                      input logic byp, input logic s1s, output logic hit);
    lu_vmid = vm; lu_page = pg; lu_req_secure = rs; lu_s1_bypass = byp; lu_s1_secure = s1s;
    #1 hit = lu_hit;
  endtask

  task automatic inv(input logic [63:0] op, input logic [7:0] vm, input logic rs,
                     input logic last, input logic rng);
    @(negedge clk);
    inv_valid = 1; inv_operand = op; inv_vmid = vm; inv_req_secure = rs;
    inv_last = last; inv_range = rng;
    @(negedge clk);
    inv_valid = 0;
    for (int k = 0; k < 40 && !inv_done; k++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] pg_op(logic b63, logic [39:0] pg);
    return {b63, 23'b0, pg};
  endfunction

  function automatic logic [63:0] rg_op(logic [1:0] tg, logic [1:0] scale, logic [4:0] num,
                                        logic [1:0] ttl, logic [36:0] base);
    return {16'b0, tg, scale, num, ttl, base};
  endfunction

  logic h;

  task automatic t_reset();
    do_reset();
    #1;
    check("R9 reset busy", inv_busy, 0);
    check("R9 reset done", inv_done, 0);
    check("R10 reset fill_ready", fill_ready, 1);
    look(8'd1, 40'h100, 0, 1, 0, h);
    check("R12 reset no hit", h, 0);
  endtask

  task automatic t_lookup();
    do_reset();
    fill(8'd1, 40'h100, 2'd3, 2'd1, 0, 0);
    look(8'd1, 40'h100, 0, 1, 0, h); check("R8 bypass ns hit", h, 1);
    check("R12 level out", lu_level, 3);
    look(8'd1, 40'h100, 1, 1, 0, h); check("R7 R8 default ns, secure req misses", h, 0);
    look(8'd1, 40'h100, 1, 0, 0, h); check("R8 s1 ns output hits", h, 1);
    look(8'd1, 40'h100, 0, 0, 1, h); check("R8 s1 secure output misses", h, 0);
    look(8'd2, 40'h100, 0, 1, 0, h); check("R12 vmid mismatch", h, 0);
    look(8'd1, 40'h101, 0, 1, 0, h); check("R12 page mismatch", h, 0);
    fill(8'd1, 40'h100, 2'd2, 2'd1, 1, 1);
    look(8'd1, 40'h100, 1, 1, 0, h); check("R7 secure fill hit", h, 1);
    check("R12 secure level", lu_level, 2);
    check("R12 partial out", lu_partial, 1);
  endtask

  task automatic pair();
    do_reset();
    fill(8'd1, 40'h100, 2'd3, 2'd1, 0, 0);
    fill(8'd1, 40'h100, 2'd3, 2'd1, 0, 1);
  endtask

  task automatic t_space();
    logic hn, hs;
    pair();
    inv(pg_op(1, 40'h100), 8'd1, 0, 0, 0);
    look(8'd1, 40'h100, 0, 1, 0, hn); look(8'd1, 40'h100, 1, 1, 0, hs);
    check("R1 ns requester clears ns", hn, 0);
    check("R1 R4 secure copy kept", hs, 1);
    pair();
    inv(pg_op(1, 40'h100), 8'd1, 1, 0, 0);
    look(8'd1, 40'h100, 0, 1, 0, hn); look(8'd1, 40'h100, 1, 1, 0, hs);
    check("R2 bit63=1 clears ns", hn, 0);
    check("R2 bit63=1 keeps secure", hs, 1);
    pair();
    inv(pg_op(0, 40'h100), 8'd1, 1, 0, 0);
    look(8'd1, 40'h100, 0, 1, 0, hn); look(8'd1, 40'h100, 1, 1, 0, hs);
    check("R2 bit63=0 keeps ns", hn, 1);
    check("R2 bit63=0 clears secure", hs, 0);
    inv(pg_op(0, 40'h100), 8'd2, 0, 0, 0);
    look(8'd1, 40'h100, 0, 1, 0, hn);
    check("R4 vmid mismatch keeps", hn, 1);
  endtask

  task automatic t_addr();
    do_reset();
    fill(8'd1, 40'h100, 2'd3, 2'd1, 0, 0);
    inv(pg_op(0, 40'h80_0000_0100), 8'd1, 0, 0, 0);
    look(8'd1, 40'h100, 0, 1, 0, h); check("R3 bit39 used", h, 1);
    inv(pg_op(0, 40'h100) | (64'd1 << 40), 8'd1, 0, 0, 0);
    look(8'd1, 40'h100, 0, 1, 0, h); check("R3 bit40 ignored", h, 0);
  endtask

  task automatic t_last();
    do_reset();
    fill(8'd1, 40'h200, 2'd1, 2'd1, 1, 0);
    inv(pg_op(0, 40'h200), 8'd1, 0, 1, 0);
    look(8'd1, 40'h200, 0, 1, 0, h); check("R5 last keeps partial", h, 1);
    inv(pg_op(0, 40'h200), 8'd1, 0, 0, 0);
    look(8'd1, 40'h200, 0, 1, 0, h); check("R5 non-last clears partial", h, 0);
  endtask

  task automatic t_range();
    do_reset();
    fill(8'd1, 40'h300, 2'd3, 2'd1, 0, 0);
    fill(8'd1, 40'h31F, 2'd2, 2'd1, 0, 0);
    fill(8'd1, 40'h320, 2'd3, 2'd1, 0, 0);
    fill(8'd1, 40'h305, 2'd3, 2'd2, 0, 0);
    inv(rg_op(2'd1, 2'd0, 5'd15, 2'd0, 37'h300), 8'd1, 0, 0, 1);
    look(8'd1, 40'h300, 0, 1, 0, h); check("R6 range base cleared", h, 0);
    look(8'd1, 40'h31F, 0, 1, 0, h); check("R6 range last page cleared", h, 0);
    look(8'd1, 40'h320, 0, 1, 0, h); check("R6 past range kept", h, 1);
    look(8'd1, 40'h305, 0, 1, 0, h); check("R6 granule mismatch kept", h, 1);
    fill(8'd1, 40'h301, 2'd3, 2'd1, 0, 0);
    fill(8'd1, 40'h302, 2'd2, 2'd1, 0, 0);
    inv(rg_op(2'd1, 2'd0, 5'd15, 2'd3, 37'h300), 8'd1, 0, 0, 1);
    look(8'd1, 40'h301, 0, 1, 0, h); check("R6 level hint match cleared", h, 0);
    look(8'd1, 40'h302, 0, 1, 0, h); check("R6 level hint mismatch kept", h, 1);
  endtask

  task automatic t_sweep();
    do_reset();
    fill(8'd1, 40'h100, 2'd3, 2'd1, 0, 0);
    fill(8'd1, 40'h200, 2'd3, 2'd1, 0, 0);
    @(negedge clk);
    inv_valid = 1; inv_operand = pg_op(0, 40'h100); inv_vmid = 8'd1;
    inv_req_secure = 0; inv_last = 0; inv_range = 0;
    @(negedge clk);
    inv_valid = 0;
    for (int i = 0; i < 8; i++) begin
      check("R9 busy during sweep", inv_busy, 1);
      check("R9 no early done", inv_done, 0);
      check("R10 fill_ready low", fill_ready, 0);
      if (i == 2) begin
        inv_valid = 1; inv_operand = pg_op(0, 40'h200);
        fill_valid = 1; fill_vmid = 8'd3; fill_page = 40'h900; fill_secure = 0;
      end
      if (i == 3) begin inv_valid = 0; fill_valid = 0; end
      @(negedge clk);
    end
    check("R9 done after last slot", inv_done, 1);
    check("R9 busy falls", inv_busy, 0);
    @(negedge clk);
    check("R9 done one cycle", inv_done, 0);
    look(8'd1, 40'h100, 0, 1, 0, h); check("R9 target cleared", h, 0);
    look(8'd1, 40'h200, 0, 1, 0, h); check("R9 mid-sweep command ignored", h, 1);
    look(8'd3, 40'h900, 0, 1, 0, h); check("R10 stalled fill dropped", h, 0);
  endtask

  task automatic t_replace();
    logic hit_all;
    do_reset();
    for (int i = 0; i < 8; i++) fill(8'd2, 40'h500 + 40'(i), 2'd3, 2'd1, 0, 0);
    hit_all = 1;
    for (int i = 0; i < 8; i++) begin
      look(8'd2, 40'h500 + 40'(i), 0, 1, 0, h); hit_all &= h;
    end
    check("R11 eight fills resident", hit_all, 1);
    fill(8'd2, 40'h600, 2'd3, 2'd1, 0, 0);
    look(8'd2, 40'h500, 0, 1, 0, h); check("R11 slot0 replaced first", h, 0);
    look(8'd2, 40'h501, 0, 1, 0, h); check("R11 slot1 kept", h, 1);
    fill(8'd2, 40'h601, 2'd3, 2'd1, 0, 0);
    look(8'd2, 40'h501, 0, 1, 0, h); check("R11 slot1 replaced next", h, 0);
    inv(pg_op(0, 40'h505), 8'd2, 0, 0, 0);
    fill(8'd2, 40'h700, 2'd3, 2'd1, 0, 0);
    look(8'd2, 40'h502, 0, 1, 0, h); check("R11 free slot preferred over pointer", h, 1);
    look(8'd2, 40'h700, 0, 1, 0, h); check("R11 new fill resident", h, 1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_lookup();
    t_space();
    t_addr();
    t_last();
    t_range();
    t_sweep();
    t_replace();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule